// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the clock-enable, command, bank and address pins of a 32-bit DDR SDRAM from reset until the memory can be used. It first keeps clock enable low with a no-operation command on the bus for a stable-clock interval. The interval is set in microseconds and turned into a cycle count from a clock-frequency parameter. It then runs the fixed bring-up order. Clock enable rises with a no-operation command. Next comes a precharge of all banks, then an extended mode write that turns the DLL on and sets the output drive strength. A mode write with the DLL-reset bit set follows, then a wait for DLL lock. After that come a second precharge-all and a run of auto refreshes. A final mode write with the DLL-reset bit cleared ends the order.

Drive strength, burst length, burst type and CAS latency arrive as configuration inputs. They are sampled in the cycle that each mode word is issued. The spacing after every command is a parameter: precharge recovery, mode-write recovery, DLL lock and refresh recovery. The number of refreshes is also a parameter. When the last mode write has had its recovery time, a done flag rises. From then on the bus carries no-operation commands until the next reset. The memory controller watches the done flag and takes over the pins when it is high.

Top module: `ddr_init_seq`

## Requirements
- R1: After the synchronous active-low reset is released, ddr_cke stays 0 and the command pins {cs_n,ras_n,cas_n,we_n} stay at NOP (0111) for exactly CLK_MHZ*STABLE_US cycles.
- R2: ddr_cke goes to 1 together with a NOP. One cycle later a precharge-all appears: command 0010, address bit 10 set, all other address bits 0 and bank 00.
- R3: T_RP cycles after the first precharge-all, an extended mode write appears. It is command 0000 with bank 01 and address bit 0 = 0, which enables the DLL. Address bits {6,1} carry the drive code (00 full, 01 weak, 11 matched impedance). Every other address bit is 0.
- R4: A drive input of 10 is reserved and is issued as 00. An extended mode write never shows bit 6 = 1 together with bit 1 = 0.
- R5: T_MRD cycles after the extended write, a mode write appears: command 0000, bank 00. Its address carries burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4 and DLL reset (bit 8) = 1. Bits 7 and 11:9 are 0.
- R6: The second precharge-all follows the DLL-reset mode write by DLL_LOCK_CYC cycles. Its encoding is the same as in R2.
- R7: Exactly NUM_REF auto refreshes follow, each with command 0001, bank 00 and address 0. The first comes T_RP cycles after the second precharge-all, and each later one comes T_RFC cycles after the one before.
- R8: T_RFC cycles after the last refresh, a final mode write appears. It has the same fields as R5 except bit 8 = 0.
- R9: init_done rises T_MRD cycles after the final mode write. It then stays 1 and ddr_cke stays 1. Only NOPs follow, and changes to the configuration inputs have no effect.
- R10: Reset held low at any point forces ddr_cke = 0, NOP, bank 00, address 0 and init_done = 0 on the next clock edge. After release the whole order starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_drive | input | 2 | Drive strength code {bit6,bit1} |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_type | input | 1 | Burst type |
| cfg_cas_lat | input | 3 | CAS latency code |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | 2 | Bank address |
| ddr_addr | output | 12 | Address / mode word |
| init_done | output | 1 | Initialization complete |

## Verification
The full power-up order is run with four configuration sets. Each set pairs a different drive code with a different mix of burst length, burst type and CAS latency. Three sets use the legal drive codes, so each drive bit must reach its own address position. The reserved code 10 shows whether it is replaced by full strength, and the varied mode fields show that every mode bit lands in its own position. Every command is checked for its exact issue cycle, which separates a wrong gap from a wrong order. A reset in the middle of the DLL wait, and configuration changes after done, show that a reset restarts cleanly and that late inputs are ignored.

// File: rtl/ddr_init_pkg.sv
// Package: shared pin encodings, step codes and mode-word builders for the
// DDR power-up sequencer. Assumes a 12-bit address bus and a 2-bit bank bus.
package ddr_init_pkg;

    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;

    // Which command the sequence engine asks the pin encoder to drive.
    typedef enum logic [2:0] {
        K_NONE,
        K_CKE_NOP,
        K_PRECH,
        K_EMRS,
        K_MRS_DLL,
        K_REFRESH,
        K_MRS_FINAL
    } step_e;

    // Command pins in the order cs_n, ras_n, cas_n, we_n.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PIN_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PIN_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t PIN_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_pins_t PIN_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    // Larger of two integers, used to size the gap timer.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Replace the reserved drive code 10 by full strength 00.
    function automatic logic [1:0] legal_drive(input logic [1:0] d);
        return (d == 2'b10) ? 2'b00 : d;
    endfunction

    // Extended mode word: DLL enabled (bit 0 low), drive code on bits 6 and 1.
    function automatic logic [ADDR_W-1:0] emrs_word(input logic [1:0] d);
        logic [ADDR_W-1:0] w;
        logic [1:0]        ld;
        ld   = legal_drive(d);
        w    = '0;
        w[1] = ld[0];
        w[6] = ld[1];
        return w;
    endfunction

    // Mode word: burst length, burst type, CAS latency, DLL reset on bit 8.
    function automatic logic [ADDR_W-1:0] mrs_word(input logic [2:0] bl,
                                                   input logic       bt,
                                                   input logic [2:0] cl,
                                                   input logic       dll_rst);
        logic [ADDR_W-1:0] w;
        w      = '0;
        w[2:0] = bl;
        w[3]   = bt;
        w[6:4] = cl;
        w[8]   = dll_rst;
        return w;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
// Gap timer: a down counter that leaves reset holding RST_VAL, can be loaded
// with a new value, and flags when it has reached zero. Assumes RST_VAL fits W.
module ddr_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Count down toward zero, reload on request, preset on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_fsm.sv
// Sequence engine: walks the fixed power-up order. Each state names the next
// command to issue. The command goes out when the gap timer reads zero, and
// the timer is then reloaded with (gap - 1). Assumes every gap is at least 1
// and NUM_REF is at least 2.
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int TW           = 16,
    parameter int T_RP         = 3,
    parameter int T_MRD        = 2,
    parameter int T_RFC        = 10,
    parameter int DLL_LOCK_CYC = 200,
    parameter int NUM_REF      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          issue,
    output step_e         step,
    output logic          done_set
);

    localparam int RW = $clog2(NUM_REF + 1);
    localparam logic [TW-1:0] G_ONE  = '0;
    localparam logic [TW-1:0] G_RP   = TW'(T_RP - 1);
    localparam logic [TW-1:0] G_MRD  = TW'(T_MRD - 1);
    localparam logic [TW-1:0] G_RFC  = TW'(T_RFC - 1);
    localparam logic [TW-1:0] G_DLL  = TW'(DLL_LOCK_CYC - 1);
    localparam logic [RW-1:0] REF_LAST = RW'(NUM_REF - 1);

    typedef enum logic [2:0] {
        S_CKE, S_PRE1, S_EMRS, S_MRS_DLL, S_PRE2, S_REF, S_MRS_FIN, S_DONE
    } st_e;

    st_e          st_q, st_d;
    logic [RW-1:0] ref_q, ref_d;

    // Choose the command, its following gap and the next state.
    always_comb begin
        st_d     = st_q;
        ref_d    = ref_q;
        issue    = 1'b0;
        step     = K_NONE;
        tmr_load = 1'b0;
        tmr_val  = '0;
        done_set = 1'b0;
        if (tmr_zero) begin
            case (st_q)
                S_CKE: begin
                    issue = 1'b1; step = K_CKE_NOP;
                    tmr_load = 1'b1; tmr_val = G_ONE; st_d = S_PRE1;
                end
                S_PRE1: begin
                    issue = 1'b1; step = K_PRECH;
                    tmr_load = 1'b1; tmr_val = G_RP; st_d = S_EMRS;
                end
                S_EMRS: begin
                    issue = 1'b1; step = K_EMRS;
                    tmr_load = 1'b1; tmr_val = G_MRD; st_d = S_MRS_DLL;
                end
                S_MRS_DLL: begin
                    issue = 1'b1; step = K_MRS_DLL;
                    tmr_load = 1'b1; tmr_val = G_DLL; st_d = S_PRE2;
                end
                S_PRE2: begin
                    issue = 1'b1; step = K_PRECH;
                    tmr_load = 1'b1; tmr_val = G_RP; st_d = S_REF;
                end
                S_REF: begin
                    issue = 1'b1; step = K_REFRESH;
                    tmr_load = 1'b1; tmr_val = G_RFC;
                    if (ref_q == REF_LAST) begin
                        st_d = S_MRS_FIN;
                    end else begin
                        ref_d = ref_q + 1'b1;
                    end
                end
                S_MRS_FIN: begin
                    issue = 1'b1; step = K_MRS_FINAL;
                    tmr_load = 1'b1; tmr_val = G_MRD; st_d = S_DONE;
                end
                default: begin
                    done_set = 1'b1;
                end
            endcase
        end
    end

    // Hold the current state and the count of refreshes already issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_CKE;
            ref_q <= '0;
        end else begin
            st_q  <= st_d;
            ref_q <= ref_d;
        end
    end

endmodule

// File: rtl/ddr_init_cmd_enc.sv
// Pin encoder: turns a requested step into registered DDR pin values. Mode
// words are built from the configuration inputs in the cycle of the request.
// Idle cycles drive NOP with bank and address at zero. Clock enable and the
// done flag are sticky until reset.
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  step_e             step,
    input  logic              done_set,
    input  logic [1:0]        cfg_drive,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    output logic              cke,
    output cmd_pins_t         pins,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    // Register the pins for the requested step, or NOP when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke  <= 1'b0;
            pins <= PIN_NOP;
            ba   <= '0;
            addr <= '0;
            done <= 1'b0;
        end else begin
            pins <= PIN_NOP;
            ba   <= '0;
            addr <= '0;
            if (done_set) begin
                done <= 1'b1;
            end
            if (issue) begin
                case (step)
                    K_CKE_NOP: cke <= 1'b1;
                    K_PRECH: begin
                        pins     <= PIN_PRE;
                        addr[10] <= 1'b1;
                    end
                    K_EMRS: begin
                        pins <= PIN_LMR;
                        ba   <= 2'b01;
                        addr <= emrs_word(cfg_drive);
                    end
                    K_MRS_DLL: begin
                        pins <= PIN_LMR;
                        addr <= mrs_word(cfg_burst_len, cfg_burst_type, cfg_cas_lat, 1'b1);
                    end
                    K_REFRESH: pins <= PIN_REF;
                    K_MRS_FINAL: begin
                        pins <= PIN_LMR;
                        addr <= mrs_word(cfg_burst_len, cfg_burst_type, cfg_cas_lat, 1'b0);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ddr_init_seq.sv
// Top of the DDR power-up sequencer: gap timer, sequence engine and pin
// encoder. Assumes the clock runs at CLK_MHZ, every gap parameter is at
// least 1, T_MRD is at least 2 and NUM_REF is at least 2.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int CLK_MHZ      = 125,
    parameter int STABLE_US    = 200,
    parameter int DLL_LOCK_CYC = 200,
    parameter int T_MRD        = 2,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 10,
    parameter int NUM_REF      = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_drive,
    input  logic [2:0]  cfg_burst_len,
    input  logic        cfg_burst_type,
    input  logic [2:0]  cfg_cas_lat,
    output logic        ddr_cke,
    output logic        ddr_cs_n,
    output logic        ddr_ras_n,
    output logic        ddr_cas_n,
    output logic        ddr_we_n,
    output logic [1:0]  ddr_ba,
    output logic [11:0] ddr_addr,
    output logic        init_done
);

    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int MAX_GAP    = max2(max2(STABLE_CYC, DLL_LOCK_CYC),
                                     max2(max2(T_MRD, T_RP), T_RFC));
    localparam int TW         = $clog2(MAX_GAP + 1);

    logic          tmr_zero;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          issue;
    step_e         step;
    logic          done_set;
    cmd_pins_t     pins;

    ddr_init_timer #(
        .W       (TW),
        .RST_VAL (STABLE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ddr_init_fsm #(
        .TW           (TW),
        .T_RP         (T_RP),
        .T_MRD        (T_MRD),
        .T_RFC        (T_RFC),
        .DLL_LOCK_CYC (DLL_LOCK_CYC),
        .NUM_REF      (NUM_REF)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .issue    (issue),
        .step     (step),
        .done_set (done_set)
    );

    ddr_init_cmd_enc u_enc (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue          (issue),
        .step           (step),
        .done_set       (done_set),
        .cfg_drive      (cfg_drive),
        .cfg_burst_len  (cfg_burst_len),
        .cfg_burst_type (cfg_burst_type),
        .cfg_cas_lat    (cfg_cas_lat),
        .cke            (ddr_cke),
        .pins           (pins),
        .ba             (ddr_ba),
        .addr           (ddr_addr),
        .done           (init_done)
    );

    assign ddr_cs_n  = pins.cs_n;
    assign ddr_ras_n = pins.ras_n;
    assign ddr_cas_n = pins.cas_n;
    assign ddr_we_n  = pins.we_n;

endmodule

// File: rtl/ddr_init_chk.sv
// Checker for the DDR power-up sequencer, bound to every ddr_init_seq.
// It watches only the pins and counts the low clock-enable window itself.
module ddr_init_chk #(
    parameter int STABLE_CYC = 25000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cke,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [11:0] addr,
    input logic        done
);

    logic [3:0]  cmd;
    logic        is_nop;
    logic        is_lmr;
    logic        is_emrs;
    logic [31:0] low_cnt;

    assign cmd     = {cs_n, ras_n, cas_n, we_n};
    assign is_nop  = (cmd == 4'b0111);
    assign is_lmr  = (cmd == 4'b0000);
    assign is_emrs = is_lmr && ba[0];

    // Count cycles since reset release with clock enable still low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!cke && low_cnt != 32'hFFFF_FFFF) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    p_nop_while_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> is_nop);

    p_stable_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (low_cnt >= 32'(STABLE_CYC)));

    p_emrs_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_emrs |-> (!ba[1] && !addr[0] && (addr & 12'hFBC) == 12'h000));

    p_no_reserved_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_emrs |-> !(addr[6] && !addr[1]));

    p_mode_write_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_lmr) |-> is_nop);

    p_cke_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_done_bus_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (is_nop && cke));

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (!cke && is_nop && !done && ba == 2'b00 && addr == 12'h000));

endmodule

bind ddr_init_seq ddr_init_chk #(
    .STABLE_CYC (CLK_MHZ * STABLE_US)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (ddr_cke),
    .cs_n  (ddr_cs_n),
    .ras_n (ddr_ras_n),
    .cas_n (ddr_cas_n),
    .we_n  (ddr_we_n),
    .ba    (ddr_ba),
    .addr  (ddr_addr),
    .done  (init_done)
);

// File: tb/sim_ddr_init_seq.sv
// Bench for ddr_init_seq: a table of configurations walked by one loop, then
// a reset in the middle of the sequence. Expected pins and cycles come from
// the requirements.
module sim_ddr_init_seq;

    localparam int CLK_MHZ = 125;
    localparam int STB_US  = 1;
    localparam int DLL     = 200;
    localparam int MRD     = 2;
    localparam int RP      = 3;
    localparam int RFC     = 8;
    localparam int NREF    = 3;
    localparam int S       = CLK_MHZ * STB_US;
    localparam int NEV     = 5 + NREF;

    // {drive[32:31], bl[30:28], bt[27], cl[26:24], emrs[23:12], mrs_final[11:0]}
    localparam logic [32:0] VEC [4] = '{
        {2'b00, 3'b001, 1'b0, 3'b010, 12'h000, 12'h021},
        {2'b01, 3'b010, 1'b1, 3'b011, 12'h002, 12'h03A},
        {2'b11, 3'b011, 1'b0, 3'b110, 12'h042, 12'h063},
        {2'b10, 3'b001, 1'b1, 3'b101, 12'h000, 12'h059}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_drive = 2'b00;
    logic [2:0]  cfg_burst_len = 3'b000;
    logic        cfg_burst_type = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'b000;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
    logic [1:0]  ddr_ba;
    logic [11:0] ddr_addr;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    ddr_init_seq #(
        .CLK_MHZ (CLK_MHZ), .STABLE_US (STB_US), .DLL_LOCK_CYC (DLL),
        .T_MRD (MRD), .T_RP (RP), .T_RFC (RFC), .NUM_REF (NREF)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .cfg_drive (cfg_drive), .cfg_burst_len (cfg_burst_len),
        .cfg_burst_type (cfg_burst_type), .cfg_cas_lat (cfg_cas_lat),
        .ddr_cke (ddr_cke), .ddr_cs_n (ddr_cs_n), .ddr_ras_n (ddr_ras_n),
        .ddr_cas_n (ddr_cas_n), .ddr_we_n (ddr_we_n), .ddr_ba (ddr_ba),
        .ddr_addr (ddr_addr), .init_done (init_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] cmd_now();
        return {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
    endfunction

    task automatic check_reset_pins(input string req);
        chk({req, " cke"}, int'(ddr_cke), 0);
        chk({req, " cmd"}, int'(cmd_now()), 4'b0111);
        chk({req, " addr"}, int'(ddr_addr), 0);
        chk({req, " done"}, int'(init_done), 0);
    endtask

    task automatic run_case(input logic [32:0] v);
        int          ev_n [NEV];
        logic [3:0]  ev_c [NEV];
        logic [1:0]  ev_b [NEV];
        logic [11:0] ev_a [NEV];
        int          x_n [NEV];
        logic [3:0]  x_c [NEV];
        logic [1:0]  x_b [NEV];
        logic [11:0] x_a [NEV];
        int n_ev = 0, cke_rise = -1, done_n = -1, bad_low = 0, lost = 0;
        int last;
        cfg_drive = v[32:31]; cfg_burst_len = v[30:28];
        cfg_burst_type = v[27]; cfg_cas_lat = v[26:24];
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_pins("R10 reset");
        rst_n = 1'b1;
        // expected command order and cycles (R2, R3, R5, R6, R7, R8)
        x_n[0] = S + 1;           x_c[0] = 4'b0010; x_b[0] = 2'b00; x_a[0] = 12'h400;
        x_n[1] = x_n[0] + RP;     x_c[1] = 4'b0000; x_b[1] = 2'b01; x_a[1] = v[23:12];
        x_n[2] = x_n[1] + MRD;    x_c[2] = 4'b0000; x_b[2] = 2'b00; x_a[2] = v[11:0] | 12'h100;
        x_n[3] = x_n[2] + DLL;    x_c[3] = 4'b0010; x_b[3] = 2'b00; x_a[3] = 12'h400;
        for (int r = 0; r < NREF; r++) begin
            x_n[4 + r] = x_n[3] + RP + r * RFC;
            x_c[4 + r] = 4'b0001; x_b[4 + r] = 2'b00; x_a[4 + r] = 12'h000;
        end
        x_n[NEV-1] = x_n[NEV-2] + RFC; x_c[NEV-1] = 4'b0000;
        x_b[NEV-1] = 2'b00;            x_a[NEV-1] = v[11:0];
        last = x_n[NEV-1] + MRD + 40;
        for (int n = 1; n <= last; n++) begin
            @(negedge clk);
            if (!ddr_cke && cmd_now() != 4'b0111) bad_low++;
            if (ddr_cke && cke_rise < 0) cke_rise = n;
            if (cke_rise >= 0 && !ddr_cke) lost++;
            if (cmd_now() != 4'b0111) begin
                if (n_ev < NEV) begin
                    ev_n[n_ev] = n; ev_c[n_ev] = cmd_now();
                    ev_b[n_ev] = ddr_ba; ev_a[n_ev] = ddr_addr;
                end
                n_ev++;
            end
            if (init_done && done_n < 0) done_n = n;
            if (done_n >= 0 && !init_done) lost++;
            if (done_n >= 0 && n == done_n + 5) begin
                cfg_drive = ~cfg_drive; cfg_cas_lat = ~cfg_cas_lat;
            end
        end
        chk("R1 cke rise cycle", cke_rise, S);
        chk("R1 NOP while cke low", bad_low, 0);
        chk("R9 command count", n_ev, NEV);
        for (int i = 0; i < NEV; i++) begin
            if (i < n_ev) begin
                chk("R2/R3/R5-R8 cycle", ev_n[i], x_n[i]);
                chk("R2/R3/R5-R8 cmd", int'(ev_c[i]), int'(x_c[i]));
                chk("R3 R7 bank", int'(ev_b[i]), int'(x_b[i]));
                chk("R3 R4 R5 R8 addr", int'(ev_a[i]), int'(x_a[i]));
            end
        end
        chk("R9 done cycle", done_n, x_n[NEV-1] + MRD);
        chk("R9 cke and done sticky", lost, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // main loop over the configuration table (R1..R9)
        for (int k = 0; k < 4; k++) begin
            run_case(VEC[k]);
        end
        // directed: reset in the middle of the DLL wait (R10), then a clean rerun
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (S + 60) @(negedge clk);
        chk("R10 mid-run cke high before reset", int'(ddr_cke), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_pins("R10 mid-run reset");
        run_case(VEC[2]);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule